// File: doc/BRIEF.md
# Memory-Mapped Parallel Port Adapter

This block is an 8-bit general-purpose parallel port that sits on a small byte-wide processor bus. Software reaches it through eight register slots, selected by a 3-bit offset while an active-high chip select is high. Through these slots software sets a global enable and a per-pin direction, drives output levels, reads pin levels, picks a rising or falling edge for each pin, turns on a pull-up per pin and sets up interrupt relaying.

Every input pin passes through a two-stage synchroniser. The first stage captures on the falling bus-clock edge and the second on the rising edge. A per-pin edge detector then compares each synchronised sample with the one before it. When it sees the chosen edge on a pin set as an input, it sets a sticky flag. Any flag whose enable bit is set pulls the active-low interrupt request low. Clearing the global enable freezes flag setting, releases the interrupt and turns off every pin driver. All register contents are kept while the port is disabled.

Pins are modelled as separate input, output-level and output-enable vectors. A fourth vector carries the pull-up enables to the pad.

Top module: `parport_adapter`

## Requirements
- R1: After synchronous reset, every register reads 0, `irq_n` is 1, `pin_oe` is 0 and `bus_rdata` is 0, so the port starts disabled.
- R2: The register offsets are 0 control, 1 data, 2 direction, 3 interrupt enable, 4 interrupt flag, 5 edge polarity and 6 pull-up. A write takes effect when `bus_cs` and `bus_we` are both 1 at a rising edge. Direction, enable, polarity and pull-up read back the value written.
- R3: When a direction bit is 1 and the port is enabled, the matching `pin_oe` bit is 1 and `pin_out` carries the data register bit. A data read returns the data register bit for output pins and the synchronised pin level for input pins.
- R4: A pin level is first captured on a falling clock edge, then on the next rising edge. It is visible to a data read presented after that rising edge.
- R5: On an input pin (direction 0), a rising edge sets the flag bit when polarity is 1 and a falling edge sets it when polarity is 0. The opposite edge does nothing. Output pins never set flags. Each edge sets the flag only once.
- R6: A flag bit stays set until software writes 0 to it at offset 4. Writing 1 to a flag bit leaves it unchanged. If an edge arrives in the same cycle as a clear, the flag ends up set.
- R7: `irq_n` is 0 exactly when the port is enabled and some flag bit and its enable bit are both 1.
- R8: Control bit 0 = 0 disables the port. While disabled, no flag is set, `irq_n` is 1 and `pin_oe` is 0, but all register contents are kept.
- R9: Control bits 7..1 and offset 7 read as 0, and writes to them have no effect.
- R10: `pin_pullup` always equals the pull-up register at offset 6, whether or not the port is enabled.
- R11: A read (`bus_cs`=1, `bus_we`=0) returns its data on `bus_rdata` in the cycle after the read is presented. `bus_rdata` is 0 in every other cycle. Without chip select, a write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables, 1 = drive |
| pin_pullup | output | 8 | Pull-up enables, 1 = connect |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench targets these corner cases, each with the fault it would expose:
- **Clear in the same cycle as a new edge.** A design where clear wins loses an interrupt, and the flag reads back as 0.
- **Edge of the opposite polarity.** A design that ignores polarity sets a flag on this edge.
- **Pin set as an output.** A design that skips the direction gate flags edges on output pins.
- **Edges while disabled.** A design that does not gate on the enable raises flags that later trigger a spurious interrupt.
- **Flag write mask.** A design with the write-1-to-clear convention inverted clears the wrong bits.
- **Reserved control bits and the unused slot.** A design that stores these writes returns non-zero reads.

A behavioural model that runs alongside the design also catches any cycle shift in the synchroniser or in the read-data register.

// File: rtl/parport_pkg.sv
package parport_pkg;
  localparam int unsigned OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_CTRL = 3'd0,
    OFS_DATA = 3'd1,
    OFS_DIR  = 3'd2,
    OFS_IEN  = 3'd3,
    OFS_FLAG = 3'd4,
    OFS_POL  = 3'd5,
    OFS_PULL = 3'd6,
    OFS_NONE = 3'd7
  } ofs_e;
endpackage

// File: rtl/parport_sync.sv
module parport_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage_a;

  // first stage catches the pad on the falling edge
  always_ff @(negedge clk) begin
    if (rst) stage_a <= '0;
    else     stage_a <= d_in;
  end

  always_ff @(posedge clk) begin
    if (rst) q_out <= '0;
    else     q_out <= stage_a;
  end
endmodule

// File: rtl/parport_edge_flags.sv
module parport_edge_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] samp,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] pol,
  input  logic         clr_we,
  input  logic [W-1:0] clr_keep,
  output logic [W-1:0] flags
);
  logic [W-1:0] prev_q;
  logic [W-1:0] set_v;
  logic [W-1:0] flags_nx;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise, fall;
    assign rise        = samp[i] & ~prev_q[i];
    assign fall        = ~samp[i] & prev_q[i];
    assign set_v[i]    = en & ~dir[i] & (pol[i] ? rise : fall);
    // a new edge beats a simultaneous software clear
    assign flags_nx[i] = (flags[i] & (clr_we ? clr_keep[i] : 1'b1)) | set_v[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flags  <= '0;
    end else begin
      prev_q <= samp;
      flags  <= flags_nx;
    end
  end
endmodule

// File: rtl/parport_rdmux.sv
module parport_rdmux #(
  parameter int W = 8
) (
  input  logic [parport_pkg::OFS_W-1:0] ofs,
  input  logic                          en,
  input  logic [W-1:0]                  data,
  input  logic [W-1:0]                  dir,
  input  logic [W-1:0]                  samp,
  input  logic [W-1:0]                  ien,
  input  logic [W-1:0]                  flags,
  input  logic [W-1:0]                  pol,
  input  logic [W-1:0]                  pull,
  output logic [W-1:0]                  rd
);
  import parport_pkg::*;

  always_comb begin
    rd = '0;
    case (ofs_e'(ofs))
      OFS_CTRL: rd[0] = en;
      OFS_DATA: rd = (dir & data) | (~dir & samp);
      OFS_DIR:  rd = dir;
      OFS_IEN:  rd = ien;
      OFS_FLAG: rd = flags;
      OFS_POL:  rd = pol;
      OFS_PULL: rd = pull;
      default:  rd = '0;
    endcase
  end
endmodule

// File: rtl/parport_adapter.sv
module parport_adapter #(
  parameter int W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_cs,
  input  logic                          bus_we,
  input  logic [parport_pkg::OFS_W-1:0] bus_addr,
  input  logic [W-1:0]                  bus_wdata,
  output logic [W-1:0]                  bus_rdata,
  input  logic [W-1:0]                  pin_in,
  output logic [W-1:0]                  pin_out,
  output logic [W-1:0]                  pin_oe,
  output logic [W-1:0]                  pin_pullup,
  output logic                          irq_n
);
  import parport_pkg::*;

  logic         en_q;
  logic [W-1:0] data_q, dir_q, ien_q, pol_q, pull_q;
  logic [W-1:0] samp, flag_q, rd_mux;
  logic         wr_hit, rd_hit;

  assign wr_hit = bus_cs & bus_we;
  assign rd_hit = bus_cs & ~bus_we;

  parport_sync #(.W(W)) sync_i (
    .clk(clk), .rst(rst), .d_in(pin_in), .q_out(samp)
  );

  parport_edge_flags #(.W(W)) flags_i (
    .clk(clk), .rst(rst), .en(en_q), .samp(samp), .dir(dir_q), .pol(pol_q),
    .clr_we(wr_hit && bus_addr == OFS_FLAG), .clr_keep(bus_wdata),
    .flags(flag_q)
  );

  parport_rdmux #(.W(W)) rdmux_i (
    .ofs(bus_addr), .en(en_q), .data(data_q), .dir(dir_q), .samp(samp),
    .ien(ien_q), .flags(flag_q), .pol(pol_q), .pull(pull_q), .rd(rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      data_q    <= '0;
      dir_q     <= '0;
      ien_q     <= '0;
      pol_q     <= '0;
      pull_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_hit) begin
        case (ofs_e'(bus_addr))
          OFS_CTRL: en_q   <= bus_wdata[0];
          OFS_DATA: data_q <= bus_wdata;
          OFS_DIR:  dir_q  <= bus_wdata;
          OFS_IEN:  ien_q  <= bus_wdata;
          OFS_POL:  pol_q  <= bus_wdata;
          OFS_PULL: pull_q <= bus_wdata;
          default:  ;
        endcase
      end
      bus_rdata <= rd_hit ? rd_mux : '0;
    end
  end

  assign pin_out    = data_q;
  assign pin_oe     = dir_q & {W{en_q}};
  assign pin_pullup = pull_q;
  assign irq_n      = ~(en_q & |(flag_q & ien_q));
endmodule

// File: rtl/parport_adapter_chk.sv
module parport_adapter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_cs,
  input logic         bus_we,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pin_oe,
  input logic         irq_n,
  input logic         en_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] ifr_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ifr_q == '0 && pin_oe == '0 && irq_n && bus_rdata == '0));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_cs && bus_we && bus_addr == 3'd4) |=> ((~ifr_q & $past(ifr_q)) == '0));

  // R8
  disabled_noset_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> ((ifr_q & ~$past(ifr_q)) == '0));

  // R5
  output_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (|dir_q) |=> ((ifr_q & ~$past(ifr_q) & $past(dir_q)) == '0));

  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> $past(bus_cs && bus_we));

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_cs && !bus_we) |=> (bus_rdata == '0));
endmodule

bind parport_adapter parport_adapter_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_oe(pin_oe), .irq_n(irq_n), .en_q(en_q),
  .dir_q(dir_q), .ifr_q(flag_q)
);

// File: tb/parport_adapter_tb_top.sv
module parport_adapter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pin_in = '0;
  logic [7:0] bus_rdata, pin_out, pin_oe, pin_pullup;
  logic       irq_n;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  always #4 clk = ~clk;

  parport_adapter #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup), .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: register values plus a pin delay line
  logic [7:0] m_reg [0:7];
  logic [7:0] m_rd, m_neg, m_hist0, m_hist1, m_set, m_keep, m_view;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 8; k++) m_reg[k] = 8'h00;
      m_rd = 0; m_hist0 = 0; m_hist1 = 0;
      started = 1;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (m_reg[5][i]) m_set[i] = m_hist0[i] && !m_hist1[i];
        else             m_set[i] = !m_hist0[i] && m_hist1[i];
      end
      m_set = m_set & ~m_reg[2] & {8{m_reg[0][0]}};
      m_view = m_reg[bus_addr];
      if (bus_addr == 3'd1) m_view = (m_reg[2] & m_reg[1]) | (~m_reg[2] & m_hist0);
      m_rd = (bus_cs && !bus_we) ? m_view : 8'h00;
      m_keep = 8'hFF;
      if (bus_cs && bus_we) begin
        case (bus_addr)
          3'd0: m_reg[0] = {7'b0, bus_wdata[0]};
          3'd4: m_keep = bus_wdata;
          3'd7: ;
          default: m_reg[bus_addr] = bus_wdata;
        endcase
      end
      m_reg[4] = (m_reg[4] & m_keep) | m_set;
      m_hist1 = m_hist0;
      m_hist0 = m_neg;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(irq_n == !(m_reg[0][0] && (m_reg[4] & m_reg[3]) != 0), "R7 model irq_n", irq_n, 0);
      chk(pin_oe == (m_reg[0][0] ? m_reg[2] : 8'h00), "R3/R8 model pin_oe", pin_oe, m_reg[2]);
      chk(pin_out == m_reg[1], "R3 model pin_out", pin_out, m_reg[1]);
      chk(pin_pullup == m_reg[6], "R10 model pin_pullup", pin_pullup, m_reg[6]);
      chk(bus_rdata == m_rd, "R11/R4 model bus_rdata", bus_rdata, m_rd);
    end
    m_neg = rst ? 8'h00 : pin_in;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    bus_cs = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_cs = 0;
    @(negedge clk);
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(irq_n == 1 && pin_oe == 0 && bus_rdata == 0, "R1 reset outputs", {irq_n, pin_oe}, 9'h100);
    rd(3'd0, 8'h00, "R1 control after reset");
    rd(3'd4, 8'h00, "R1 flags after reset");

    wr(3'd0, 8'hFE);
    rd(3'd0, 8'h00, "R9 reserved control bits");
    wr(3'd7, 8'hFF);
    rd(3'd7, 8'h00, "R9 unused offset");
    wr(3'd2, 8'hF0); wr(3'd1, 8'hA5); wr(3'd6, 8'h5A); wr(3'd5, 8'h0F);
    rd(3'd2, 8'hF0, "R2 direction readback");
    rd(3'd5, 8'h0F, "R2 polarity readback");
    rd(3'd6, 8'h5A, "R2 pull-up readback");
    chk(pin_pullup == 8'h5A, "R10 pull-up output while disabled", pin_pullup, 8'h5A);
    chk(pin_oe == 8'h00, "R8 oe off while disabled", pin_oe, 0);

    // no chip select: write ignored
    @(posedge clk); #1; bus_we = 1; bus_addr = 3'd2; bus_wdata = 8'h00;
    @(posedge clk); #1; bus_we = 0;
    rd(3'd2, 8'hF0, "R11 write without chip select");

    wr(3'd0, 8'h01);
    rd(3'd0, 8'h01, "R2 control enable readback");
    chk(pin_oe == 8'hF0 && pin_out == 8'hA5, "R3 outputs driven", {pin_oe, pin_out}, 16'hF0A5);

    pin_in = 8'h3C;
    idle(4);
    rd(3'd1, 8'hAC, "R3 R4 mixed data read");
    rd(3'd4, 8'h0C, "R5 rising flags on inputs only");
    wr(3'd4, 8'hF7);
    rd(3'd4, 8'h04, "R6 write-zero clears only that bit");
    chk(irq_n == 1, "R7 irq high with enables off", irq_n, 1);
    wr(3'd3, 8'h04);
    @(negedge clk);
    chk(irq_n == 0, "R7 irq low on enabled flag", irq_n, 0);

    wr(3'd0, 8'h00);
    @(negedge clk);
    chk(irq_n == 1, "R8 irq released when disabled", irq_n, 1);
    wr(3'd5, 8'h00);
    pin_in = 8'h30;
    idle(4);
    rd(3'd4, 8'h04, "R8 no flags while disabled, contents kept");
    wr(3'd0, 8'h01);
    @(negedge clk);
    chk(irq_n == 0, "R7 irq returns on re-enable", irq_n, 0);

    wr(3'd4, 8'h00);
    pin_in = 8'h34;
    idle(4);
    rd(3'd4, 8'h00, "R5 opposite edge ignored");
    pin_in = 8'h30;
    idle(4);
    rd(3'd4, 8'h04, "R5 falling edge flagged");
    wr(3'd4, 8'h00);
    idle(4);
    rd(3'd4, 8'h00, "R5 edge reported once");

    wr(3'd5, 8'h04);
    @(posedge clk); #1; pin_in = 8'h34;
    @(posedge clk); #1; bus_cs = 1; bus_we = 1; bus_addr = 3'd4; bus_wdata = 8'h00;
    @(posedge clk); #1; bus_cs = 0; bus_we = 0;
    rd(3'd4, 8'h04, "R6 set wins over simultaneous clear");
    @(negedge clk);
    chk(bus_rdata == 8'h00, "R11 rdata returns to zero", bus_rdata, 0);

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule